// File: doc/BRIEF.md
# Cost-Aware Victim Selector

This block chooses which way of a set-associative cache set is replaced when a miss is being serviced. For every way of the addressed set it receives a quantized miss cost, a confidence bit and a valid bit, together with a shared threshold. A valid way whose cost is strictly above the threshold and whose confidence bit is set is cheap to lose, and so it is an eviction candidate. One candidate is drawn at random. When the set has no candidate, the way that was used least recently is replaced instead. An empty way always wins over every other rule.

The block also holds the recency state of every set, as a full age order. Hits and fills are reported on a separate touch port. Selection sits next to the miss path and never touches the hit path. A request is accepted in one cycle and the answer comes with a one-cycle done strobe on the next. The default geometry is 8 ways and 16 sets, with 5-bit costs.

A two-state controller sequences the answer. SEL_IDLE moves to SEL_REPORT when a request arrives. SEL_REPORT stays in SEL_REPORT when a further request arrives in the same cycle (back-to-back). SEL_REPORT returns to SEL_IDLE when no request arrives. The done output is high exactly while the controller is in SEL_REPORT.

Top module: `cost_victim_sel`

## Requirements
- R1: A way is a cheap candidate only if it is valid, its confidence bit is 1 and its cost (way w in bits w*COST_W upward of `way_cost`) is strictly greater than `threshold`; a cost equal to the threshold, or a clear confidence bit, excludes it.
- R2: When all ways are valid and at least one cheap candidate exists, the victim is a candidate, and across repeated requests with the same candidates more than one of them is chosen (pseudo-random pick stepped on every request).
- R3: When any way is invalid (bit w of `way_valid` is 0), the victim is the lowest-numbered invalid way, whatever the costs.
- R4: When all ways are valid and there is no candidate, the victim is the least recently used way of the requested set.
- R5: `done` is high in the cycle after each cycle with `req_valid` high, and at no other time; back-to-back requests give back-to-back strobes.
- R6: A touch of way w in a set makes w the most recent way; ways that were more recent than w age by one, and older ways keep their place.
- R7: After reset `done` is low and every set has way 0 as most recent up to way WAYS-1 as least recent.
- R8: A touch changes the recency order of the touched set only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Victim request for a miss |
| req_set | input | SET_W | Set being filled |
| way_cost | input | WAYS*COST_W | Per-way quantized cost, way 0 in the low bits |
| way_conf | input | WAYS | Per-way confidence bit |
| way_valid | input | WAYS | Per-way valid bit |
| threshold | input | COST_W | Current cost threshold |
| touch_valid | input | 1 | Hit or fill reported |
| touch_set | input | SET_W | Set of the touch |
| touch_way | input | WAY_W | Way that was touched |
| done | output | 1 | Victim strobe, one cycle after a request |
| victim_way | output | WAY_W | Selected way, valid while done is high |

## Verification
The victim and its done strobe are due one clock edge after the request edge. The bench raises the request on a falling edge, drops it on the next falling edge and samples done and the victim right there, then confirms that done has fallen one falling edge later. A touch updates the age order at the edge after it is driven, so the bench applies each touch on the same falling-edge schedule and updates its arithmetic age model at once. Every later request is compared with the least recent way that the model computes.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
    typedef enum logic [0:0] {
        SEL_IDLE   = 1'b0,
        SEL_REPORT = 1'b1
    } sel_state_e;
endpackage

// File: rtl/cvs_lfsr.sv
module cvs_lfsr #(
    parameter int          LFSR_W = 16,
    parameter int          OUT_W  = 3,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] rnd
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_d;

    always_comb begin
        state_d = {1'b0, state_q[LFSR_W-1:1]};
        if (state_q[0]) begin
            state_d = state_d ^ TAPS[LFSR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED[LFSR_W-1:0];
        end else if (step) begin
            state_q <= state_d;
        end
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/cvs_recency.sv
module cvs_recency #(
    parameter int WAYS = 8,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] lru_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic hit_here;
        logic [WAY_W-1:0] touched_age;
        assign hit_here    = touch_valid && (touch_set == SET_W'(s));
        assign touched_age = age_q[s][touch_way];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end else if (hit_here) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (touch_way == WAY_W'(w)) begin
                        age_q[s][w] <= '0;
                    end else if (age_q[s][w] < touched_age) begin
                        age_q[s][w] <= age_q[s][w] + WAY_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (age_q[rd_set][w] == OLDEST) begin
                lru_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cvs_pick.sv
module cvs_pick #(
    parameter int WAYS   = 8,
    parameter int COST_W = 5,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS*COST_W-1:0] way_cost,
    input  logic [WAYS-1:0]        way_conf,
    input  logic [WAYS-1:0]        way_valid,
    input  logic [COST_W-1:0]      threshold,
    input  logic [WAY_W-1:0]       rot,
    input  logic [WAY_W-1:0]       lru_way,
    output logic [WAY_W-1:0]       victim
);
    logic [WAYS-1:0]   cheap;
    logic [2*WAYS-1:0] doubled;
    logic [WAYS-1:0]   rotated;
    logic [WAY_W-1:0]  first_empty;
    logic [WAY_W-1:0]  first_rot;
    logic              any_empty;
    logic              any_cheap;

    for (genvar w = 0; w < WAYS; w++) begin : g_class
        assign cheap[w] = way_valid[w] && way_conf[w] &&
                          (way_cost[w*COST_W +: COST_W] > threshold);
    end

    assign doubled   = {cheap, cheap};
    assign rotated   = WAYS'(doubled >> rot);
    assign any_empty = ~&way_valid;
    assign any_cheap = |cheap;

    always_comb begin
        first_empty = '0;
        first_rot   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                first_empty = WAY_W'(w);
            end
            if (rotated[w]) begin
                first_rot = WAY_W'(w);
            end
        end
    end

    always_comb begin
        if (any_empty) begin
            victim = first_empty;
        end else if (any_cheap) begin
            victim = first_rot + rot;
        end else begin
            victim = lru_way;
        end
    end
endmodule

// File: rtl/cost_victim_sel.sv
module cost_victim_sel
    import cvs_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int SETS   = 16,
    parameter int COST_W = 5,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [SET_W-1:0]       req_set,
    input  logic [WAYS*COST_W-1:0] way_cost,
    input  logic [WAYS-1:0]        way_conf,
    input  logic [WAYS-1:0]        way_valid,
    input  logic [COST_W-1:0]      threshold,
    input  logic                   touch_valid,
    input  logic [SET_W-1:0]       touch_set,
    input  logic [WAY_W-1:0]       touch_way,
    output logic                   done,
    output logic [WAY_W-1:0]       victim_way
);
    sel_state_e       state_q;
    sel_state_e       state_d;
    logic [WAY_W-1:0] rnd_w;
    logic [WAY_W-1:0] lru_way_w;
    logic [WAY_W-1:0] pick_w;
    logic [WAY_W-1:0] victim_q;

    cvs_lfsr #(.LFSR_W(16), .OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_valid),
        .rnd   (rnd_w)
    );

    cvs_recency #(.WAYS(WAYS), .SETS(SETS)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_valid (touch_valid),
        .touch_set   (touch_set),
        .touch_way   (touch_way),
        .rd_set      (req_set),
        .lru_way     (lru_way_w)
    );

    cvs_pick #(.WAYS(WAYS), .COST_W(COST_W)) u_pick (
        .way_cost  (way_cost),
        .way_conf  (way_conf),
        .way_valid (way_valid),
        .threshold (threshold),
        .rot       (rnd_w),
        .lru_way   (lru_way_w),
        .victim    (pick_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE:   state_d = req_valid ? SEL_REPORT : SEL_IDLE;
            SEL_REPORT: state_d = req_valid ? SEL_REPORT : SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (req_valid) begin
            victim_q <= pick_w;
        end
    end

    assign done       = (state_q == SEL_REPORT);
    assign victim_way = victim_q;
endmodule

// File: rtl/cvs_chk.sv
module cvs_chk #(
    parameter int WAYS   = 8,
    parameter int COST_W = 5,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [WAYS*COST_W-1:0] way_cost,
    input logic [WAYS-1:0]        way_conf,
    input logic [WAYS-1:0]        way_valid,
    input logic [COST_W-1:0]      threshold,
    input logic [WAY_W-1:0]       lru_way,
    input logic                   done,
    input logic [WAY_W-1:0]       victim_way
);
    logic [WAYS*COST_W-1:0] cost_q;
    logic [WAYS-1:0]        conf_q;
    logic [WAYS-1:0]        valid_q;
    logic [COST_W-1:0]      thr_q;
    logic [WAY_W-1:0]       lru_q;
    logic [WAYS-1:0]        cand_q;
    logic [WAYS-1:0]        below;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost_q  <= '0;
            conf_q  <= '0;
            valid_q <= '1;
            thr_q   <= '0;
            lru_q   <= '0;
        end else if (req_valid) begin
            cost_q  <= way_cost;
            conf_q  <= way_conf;
            valid_q <= way_valid;
            thr_q   <= threshold;
            lru_q   <= lru_way;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            cand_q[w] = valid_q[w] & conf_q[w] &
                        (cost_q[w*COST_W +: COST_W] > thr_q);
        end
    end

    assign below = (WAYS'(1) << victim_way) - WAYS'(1);

    // R5
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    // R5
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid));

    // R3
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(&valid_q)) |-> (!valid_q[victim_way] && ((~valid_q & below) == '0)));

    // R2
    cheap_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&valid_q) && (cand_q != '0)) |-> cand_q[victim_way]);

    // R4
    oldest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&valid_q) && (cand_q == '0)) |-> (victim_way == lru_q));
endmodule

bind cost_victim_sel cvs_chk #(.WAYS(WAYS), .COST_W(COST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .way_cost   (way_cost),
    .way_conf   (way_conf),
    .way_valid  (way_valid),
    .threshold  (threshold),
    .lru_way    (lru_way_w),
    .done       (done),
    .victim_way (victim_way)
);

// File: tb/tb_cost_victim_sel.sv
module tb_cost_victim_sel;
    localparam int WAYS = 8;
    localparam int SETS = 4;
    localparam int CW   = 5;
    localparam int WW   = $clog2(WAYS);
    localparam int SW   = $clog2(SETS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [SW-1:0] req_set = '0;
    logic [WAYS*CW-1:0] way_cost = '0;
    logic [WAYS-1:0] way_conf = '0;
    logic [WAYS-1:0] way_valid = '1;
    logic [CW-1:0] threshold = '0;
    logic touch_valid = 1'b0;
    logic [SW-1:0] touch_set = '0;
    logic [WW-1:0] touch_way = '0;
    logic done;
    logic [WW-1:0] victim_way;

    int checks = 0;
    int errors = 0;
    int age [SETS][WAYS];
    bit finished = 0;

    always #5 clk = ~clk;

    cost_victim_sel #(.WAYS(WAYS), .SETS(SETS), .COST_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .way_cost(way_cost), .way_conf(way_conf), .way_valid(way_valid),
        .threshold(threshold), .touch_valid(touch_valid), .touch_set(touch_set),
        .touch_way(touch_way), .done(done), .victim_way(victim_way)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_lru(input int s);
        int r = 0;
        for (int w = 0; w < WAYS; w++) if (age[s][w] == WAYS - 1) r = w;
        return r;
    endfunction

    task automatic touch(input int s, input int w);
        int a;
        @(negedge clk);
        touch_valid = 1'b1; touch_set = SW'(s); touch_way = WW'(w);
        @(negedge clk);
        touch_valid = 1'b0;
        a = age[s][w];
        for (int v = 0; v < WAYS; v++) if (age[s][v] < a) age[s][v]++;
        age[s][w] = 0;
    endtask

    task automatic request(input int s, output int v, output bit d);
        @(negedge clk);
        req_valid = 1'b1; req_set = SW'(s);
        @(negedge clk);
        req_valid = 1'b0;
        d = done; v = int'(victim_way);
    endtask

    task automatic set_all(input int cost, input bit conf);
        for (int w = 0; w < WAYS; w++) way_cost[w*CW +: CW] = CW'(cost);
        way_conf = conf ? '1 : '0;
        way_valid = '1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        bit d;
        bit seen_lo, seen_hi;
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) age[s][w] = w;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R7 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R7 done low after reset", int'(done), 0);

        // R7 / R4: reset order gives oldest way WAYS-1 in every set
        set_all(0, 1'b0);
        for (int s = 0; s < SETS; s++) begin
            request(s, v, d);
            chk(d, "R5 done after request", int'(d), 1);
            chk(v == WAYS - 1, "R7 reset oldest way", v, WAYS - 1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R5 done single strobe", int'(done), 0);

        // R6 / R8: touch sweep with model comparison in two sets
        for (int k = 0; k < 12; k++) begin
            touch(0, (k * 5 + 3) % WAYS);
            request(0, v, d);
            chk(v == model_lru(0), "R6 oldest after touch", v, model_lru(0));
            request(1, v, d);
            chk(v == model_lru(1), "R8 other set unchanged", v, model_lru(1));
        end
        for (int s = 1; s < SETS; s++) begin
            for (int k = 0; k < 10; k++) touch(s, (s * 3 + k * 7) % WAYS);
        end
        for (int s = 0; s < SETS; s++) begin
            request(s, v, d);
            chk(v == model_lru(s), "R4 oldest per set", v, model_lru(s));
        end

        // R3: a single empty way beats cheap candidates
        for (int w = 0; w < WAYS; w++) begin
            set_all(20, 1'b1);
            threshold = CW'(2);
            way_valid[w] = 1'b0;
            request(2, v, d);
            chk(v == w, "R3 single empty way", v, w);
            for (int w2 = w + 1; w2 < WAYS; w2++) begin
                way_valid[w2] = 1'b0;
                request(2, v, d);
                chk(v == w, "R3 lowest empty way", v, w);
                way_valid[w2] = 1'b1;
            end
        end

        // R1: one way just above threshold, rest equal to threshold
        for (int t = 0; t < 32; t += 5) begin
            for (int w = 0; w < WAYS; w++) begin
                set_all(t, 1'b1);
                threshold = CW'(t);
                way_cost[w*CW +: CW] = CW'(t + 1);
                request(3, v, d);
                chk(v == w, "R1 strict greater picks way", v, w);
                way_conf[w] = 1'b0;
                request(3, v, d);
                chk(v == model_lru(3), "R1 clear confidence excluded", v, model_lru(3));
            end
        end
        set_all(31, 1'b1);
        threshold = CW'(31);
        request(3, v, d);
        chk(v == model_lru(3), "R1 cost equal to max threshold", v, model_lru(3));

        // R2: candidates ways 1 and 6 only
        set_all(0, 1'b1);
        threshold = CW'(4);
        way_cost[1*CW +: CW] = CW'(9);
        way_cost[6*CW +: CW] = CW'(30);
        seen_lo = 0; seen_hi = 0;
        for (int k = 0; k < 40; k++) begin
            request(0, v, d);
            chk(v == 1 || v == 6, "R2 victim is candidate", v, 1);
            if (v == 1) seen_lo = 1;
            if (v == 6) seen_hi = 1;
        end
        chk(seen_lo && seen_hi, "R2 both candidates chosen", int'(seen_lo) + int'(seen_hi), 2);

        // R5: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_set = '0;
        @(negedge clk);
        chk(done == 1'b1, "R5 first strobe", int'(done), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R5 second strobe", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R5 strobe ends", int'(done), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule